// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block guards a small peripheral register file against stray software writes. At reset it starts locked. Software opens it with two key words written to two separate key registers, one after the other. While it is locked, every write to a guarded register is dropped. Any other value written to either key register closes the gate again. Writing zero to both key registers is the normal way to relock.

The gate holds three 32-bit scratch words and an interrupt-enable word behind this protection. It also forwards a write strobe for the timekeeping, control and oscillator registers, which sit outside the block. That strobe is high only while the gate is open, so those registers never have to look at the keys themselves. The bus is a plain single-cycle port. Writes take effect at the clock edge and reads are combinational.

Top module: `regfile_keygate`

## Requirements
- R1: After reset the gate is locked (`unlocked`=0). Both key registers, all scratch words and `irq_en` read as zero.
- R2: Write 0x83E70B13 to the first key register (offset 0x6C), then write 0x95A4F1E0 to the second key register (offset 0x70). `unlocked` rises in the cycle after the second write.
- R3: A correct second key does not unlock if the most recent write to the first key register held a different value, or if the first key register was never written.
- R4: Writing any non-key value to either key register clears `unlocked` from the next cycle. Writing 0 to both key registers leaves the gate locked.
- R5: A key register write counts as its key only if all four byte strobes are set. Each key register reads back the last data word written to it.
- R6: The scratch words at 0x60, 0x64 and 0x68 take writes per byte lane (strobe bit n covers data bits 8n+7..8n), and only while unlocked. Blocked writes leave them unchanged. Reads are allowed at all times.
- R7: The interrupt-enable word at 0x48 takes byte-lane writes only while unlocked and drives `irq_en`. A full-strobe write of zero clears it completely.
- R8: `prot_we` is high in the same cycle as a write to 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x40 or 0x54, and only while the gate is unlocked. It is low in every other case.
- R9: Reads from any offset other than the scratch, key and interrupt-enable offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write request for this cycle |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| unlocked | output | 1 | The gate is open |
| prot_we | output | 1 | Write strobe passed to the external guarded registers |
| irq_en | output | 32 | Interrupt-enable word |

## Verification
The internal state that matters is the half-sequence flag, which records whether the first key was seen. If that flag is wrong, the fault shows one cycle after a second-key write: `unlocked` either rises when it should not or stays low when it should rise. If the lock bit itself is wrong, the next scratch or interrupt-enable write either sticks or is dropped, and a read one cycle later shows which. `prot_we` shows the error in the same cycle as the write. The bench therefore reads back or samples each output within a cycle of the stimulus that could have disturbed it.

// File: rtl/regfile_keygate.sv
module regfile_keygate #(
  parameter int          AW   = 8,
  parameter logic [31:0] KEY0 = 32'h83E7_0B13,
  parameter logic [31:0] KEY1 = 32'h95A4_F1E0,
  parameter int          NSCR = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          unlocked,
  output logic          prot_we,
  output logic [31:0]   irq_en
);
  localparam logic [AW-1:0] OFS_IRQ  = AW'(8'h48);
  localparam logic [AW-1:0] OFS_SCR  = AW'(8'h60);
  localparam logic [AW-1:0] OFS_K0   = AW'(8'h6C);
  localparam logic [AW-1:0] OFS_K1   = AW'(8'h70);
  localparam logic [AW-1:0] OFS_TEND = AW'(8'h18);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h40);
  localparam logic [AW-1:0] OFS_OSC  = AW'(8'h54);

  logic [31:0] kick0, kick1;
  logic [31:0] scr [NSCR];
  logic        key0_seen;
  logic [31:0] lane;

  wire full   = (bus_be == 4'hF);
  wire wr_k0  = bus_we && bus_addr == OFS_K0;
  wire wr_k1  = bus_we && bus_addr == OFS_K1;
  wire good0  = full && bus_wdata == KEY0;
  wire good1  = full && bus_wdata == KEY1;
  wire time_a = bus_addr <= OFS_TEND && bus_addr[1:0] == 2'b00;

  assign lane    = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign prot_we = bus_we && unlocked && (time_a || bus_addr == OFS_CTRL || bus_addr == OFS_OSC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick0     <= '0;
      kick1     <= '0;
      key0_seen <= 1'b0;
      unlocked  <= 1'b0;
    end else begin
      if (wr_k0) begin
        kick0     <= bus_wdata;
        key0_seen <= good0;
        if (!good0) unlocked <= 1'b0;
      end
      if (wr_k1) begin
        kick1    <= bus_wdata;
        unlocked <= good1 && key0_seen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      for (int i = 0; i < NSCR; i++) scr[i] <= '0;
    end else if (bus_we && unlocked) begin
      if (bus_addr == OFS_IRQ) irq_en <= (irq_en & ~lane) | (bus_wdata & lane);
      for (int i = 0; i < NSCR; i++)
        if (bus_addr == OFS_SCR + AW'(4 * i)) scr[i] <= (scr[i] & ~lane) | (bus_wdata & lane);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_K0)  bus_rdata = kick0;
    if (bus_addr == OFS_K1)  bus_rdata = kick1;
    if (bus_addr == OFS_IRQ) bus_rdata = irq_en;
    for (int i = 0; i < NSCR; i++)
      if (bus_addr == OFS_SCR + AW'(4 * i)) bus_rdata = scr[i];
  end

  a_r2_rise_needs_key1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && bus_addr == OFS_K1 && bus_wdata == KEY1 && bus_be == 4'hF));

  a_r4_bad_kick_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == OFS_K0 || bus_addr == OFS_K1) &&
     !(bus_be == 4'hF && (bus_wdata == KEY0 || bus_wdata == KEY1))) |=> !unlocked);

  a_r6_locked_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(scr[0]) && $stable(scr[NSCR-1]));

  a_r7_locked_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(irq_en));

  a_r8_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    prot_we |-> unlocked && bus_we);

  a_r3_no_unlock_from_k0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_K0 && !unlocked) |=> !unlocked);
endmodule

// File: tb/test_regfile_keygate.sv
`timescale 1ns/1ps
module test_regfile_keygate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        unlocked, prot_we;
  logic [31:0] irq_en;
  int checks = 0, errors = 0;

  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;

  always #2.5 clk = ~clk;

  regfile_keygate i_regfile_keygate (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unlocked(unlocked), .prot_we(prot_we), .irq_en(irq_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic strobe_chk(input string req, input logic [7:0] a, input logic exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_be = 4'hF; bus_wdata = 32'h1;
    #1 chk(req, {31'b0, prot_we}, {31'b0, exp});
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic open_gate();
    wr(8'h6C, K0);
    wr(8'h70, K1);
  endtask

  task automatic t_reset();
    #1 chk("R1 unlocked", {31'b0, unlocked}, 32'h0);
    chk("R1 irq_en", irq_en, 32'h0);
    rd_chk("R1 kick0", 8'h6C, 32'h0);
    rd_chk("R1 kick1", 8'h70, 32'h0);
    rd_chk("R1 scratch0", 8'h60, 32'h0);
  endtask

  task automatic t_blocked();
    wr(8'h64, 32'hDEAD_BEEF);
    rd_chk("R6 locked scratch1", 8'h64, 32'h0);
    wr(8'h48, 32'h0000_00FF);
    #1 chk("R7 locked irq", irq_en, 32'h0);
    strobe_chk("R8 locked ctrl", 8'h40, 1'b0);
  endtask

  task automatic t_bad_order();
    wr(8'h70, K1);
    #1 chk("R3 key1 alone", {31'b0, unlocked}, 32'h0);
    wr(8'h6C, 32'h1234_5678);
    wr(8'h70, K1);
    #1 chk("R3 wrong key0", {31'b0, unlocked}, 32'h0);
    wr(8'h6C, K0);
    wr(8'h6C, 32'h0);
    wr(8'h70, K1);
    #1 chk("R3 key0 overwritten", {31'b0, unlocked}, 32'h0);
  endtask

  task automatic t_unlock();
    wr(8'h6C, K0);
    #1 chk("R2 not after key0 only", {31'b0, unlocked}, 32'h0);
    wr(8'h70, K1);
    #1 chk("R2 unlocked", {31'b0, unlocked}, 32'h1);
    rd_chk("R5 kick0 readback", 8'h6C, K0);
    rd_chk("R5 kick1 readback", 8'h70, K1);
  endtask

  task automatic t_scratch();
    wr(8'h60, 32'h1122_3344);
    wr(8'h68, 32'hAABB_CCDD, 4'b0011);
    rd_chk("R6 scratch0 full", 8'h60, 32'h1122_3344);
    rd_chk("R6 scratch2 lanes", 8'h68, 32'h0000_CCDD);
    rd_chk("R6 scratch1 untouched", 8'h64, 32'h0);
    strobe_chk("R8 time 0x18", 8'h18, 1'b1);
    strobe_chk("R8 osc 0x54", 8'h54, 1'b1);
    strobe_chk("R8 gap 0x1C", 8'h1C, 1'b0);
    strobe_chk("R8 scratch 0x60", 8'h60, 1'b0);
  endtask

  task automatic t_irq();
    wr(8'h48, 32'h0000_FFFF);
    #1 chk("R7 irq set", irq_en, 32'h0000_FFFF);
    wr(8'h48, 32'h0, 4'b0001);
    #1 chk("R7 irq lane clear", irq_en, 32'h0000_FF00);
    rd_chk("R7 irq readback", 8'h48, 32'h0000_FF00);
    wr(8'h48, 32'h0);
    #1 chk("R7 irq full clear", irq_en, 32'h0);
    wr(8'h60, 32'h1122_3344);
  endtask

  task automatic t_unmapped();
    rd_chk("R9 offset 0x5C", 8'h5C, 32'h0);
    rd_chk("R9 offset 0x00", 8'h00, 32'h0);
    rd_chk("R9 offset 0x62", 8'h62, 32'h0);
  endtask

  task automatic t_relock();
    wr(8'h6C, 32'h0);
    #1 chk("R4 kick0 zero", {31'b0, unlocked}, 32'h0);
    wr(8'h60, 32'hFFFF_FFFF);
    rd_chk("R4 scratch after relock", 8'h60, 32'h1122_3344);
    open_gate();
    #1 chk("R4 reopened", {31'b0, unlocked}, 32'h1);
    wr(8'h70, 32'h0);
    #1 chk("R4 kick1 zero", {31'b0, unlocked}, 32'h0);
    wr(8'h6C, 32'h0);
    #1 chk("R4 both zero", {31'b0, unlocked}, 32'h0);
  endtask

  task automatic t_partial();
    wr(8'h6C, K0, 4'b0111);
    wr(8'h70, K1);
    #1 chk("R5 partial key0", {31'b0, unlocked}, 32'h0);
    rd_chk("R5 kick0 partial readback", 8'h6C, K0);
    wr(8'h6C, K0);
    wr(8'h70, K1, 4'b1110);
    #1 chk("R5 partial key1", {31'b0, unlocked}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #7 rst_n = 1'b1;
    t_reset();
    t_blocked();
    t_bad_order();
    t_unlock();
    t_scratch();
    t_irq();
    t_unmapped();
    t_relock();
    t_partial();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule